// File: doc/BRIEF.md
# Field Identity and Line-21 Pulse Generator

This block takes a digital composite sync stream, after analog slicing, and an integrated vertical sync level. It produces two results. The first is a pulse that covers one chosen video line, line 21 by default, so that a downstream caption data slicer knows when to look. The second is a single status pin that carries one of two things: whether a steady horizontal sync is present, or which field of the interlaced frame is being received.

Horizontal sync edges are timed in reference clocks and compared against an expected period with a percentage tolerance. A run of well-spaced edges declares sync present. Several expected periods without any edge declare it absent. The field is identified when vertical sync falls, from where that edge lands inside the current line: an edge near mid-line marks the even field. A line counter is cleared by that same edge and advanced by each horizontal sync edge. Two static select inputs set the behaviour:
- The pulse select limits the pulse to even fields or lets it appear in both fields.
- The status select picks what the status pin shows.

The vertical sync input is active low. When it is not used it is tied high, and then no field is ever started.

Top module: `fld_l21_top`

## Requirements
- R1: Directly after reset, `l21_pulse` is low, `status_out` is low with `status_sel` low (sync absent), and `status_out` is low with `status_sel` high (field flag reset to odd).
- R2: Sync is declared present on the horizontal sync rising edge that completes 8 consecutive edge-to-edge intervals, each within [H_PERIOD−tol, H_PERIOD+tol] clocks, where tol = H_PERIOD·TOL_PCT/100. Seven such intervals are not enough.
- R3: An interval outside that window adds nothing to the run and restarts the count, so edges spaced too long or too short never declare presence.
- R4: Once present, sync is declared absent after 4 expected periods pass with no horizontal sync edge, which is about 4·H_PERIOD clocks after the last edge.
- R5: With `status_sel` low, `status_out` equals the sync-present judgment: 1 present, 0 absent.
- R6: On each falling edge of `vsync_n`, the field flag is set to even (1) if the clocks elapsed since the last horizontal sync edge lie in [H_PERIOD/4, 3·H_PERIOD/4). Otherwise it is set to odd (0). With `status_sel` high, `status_out` shows this flag.
- R7: The line count is cleared to 0 by a falling edge of `vsync_n` and advanced by 1 on each rising edge of `csync`. The pulse is high while the count equals TARGET_LINE, which lasts exactly one line (H_PERIOD clocks at a steady rate).
- R8: With `l21_both` low, the pulse appears only in even fields. An odd field produces no pulse.
- R9: With `l21_both` high, the pulse appears in both odd and even fields.
- R10: While `vsync_n` stays high from reset (input unused), no pulse is produced, however many horizontal sync edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync | input | 1 | Separated composite sync; a rising edge marks a line start |
| vsync_n | input | 1 | Integrated vertical sync, active low; tied high when unused |
| l21_both | input | 1 | 0: pulse in even fields only, 1: pulse in both fields |
| status_sel | input | 1 | 0: status shows sync present, 1: status shows even field |
| l21_pulse | output | 1 | High for the whole of the target line |
| status_out | output | 1 | Multiplexed status pin |

## Verification
The bench targets the edges of the presence judgment. It sends seven good intervals and then an eighth, so a design with an off-by-one lock count would switch too early or too late. It sends spacings just outside the window on both sides, which a design with a loose or one-sided window would accept. It also pauses sync and checks just before and just after four missing periods, which catches a loss counter of the wrong length. Fields with the vertical edge near the line start and near mid-line are sent under both pulse selects, and a scoreboard compares the measured pulse width per field. A design that swapped the field sense, ignored the even-only select or miscounted lines would show a missing, extra or wrongly sized pulse.

// File: rtl/fld_l21_pkg.sv
package fld_l21_pkg;
  typedef enum logic {
    FLD_ODD  = 1'b0,
    FLD_EVEN = 1'b1
  } field_e;
endpackage

// File: rtl/hsync_judge.sv
module hsync_judge #(
  parameter int H_PERIOD = 100,
  parameter int TOL_PCT  = 5,
  parameter int LOSS_CNT = 4,
  parameter int LOCK_CNT = 8,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_edge,
  output logic          present,
  output logic [CW-1:0] since
);
  localparam int TOL = H_PERIOD * TOL_PCT / 100;
  localparam int GW  = $clog2(LOCK_CNT + 1);
  localparam int MW  = $clog2(LOSS_CNT + 1);
  localparam logic [CW-1:0] WIN_LO  = CW'(H_PERIOD - TOL);
  localparam logic [CW-1:0] WIN_HI  = CW'(H_PERIOD + TOL);
  localparam logic [CW-1:0] GAP_RST = CW'(TOL + 1);
  localparam logic [CW-1:0] SAT     = '1;
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_CNT);
  localparam logic [GW-1:0] GOOD_M1  = GW'(LOCK_CNT - 1);
  localparam logic [MW-1:0] MISS_MAX = MW'(LOSS_CNT);
  localparam logic [MW-1:0] MISS_M1  = MW'(LOSS_CNT - 1);

  logic [CW-1:0] gap;
  logic [GW-1:0] good;
  logic [MW-1:0] miss;
  logic          in_win;

  assign in_win = (since >= WIN_LO) && (since <= WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since   <= SAT;
      gap     <= CW'(1);
      good    <= '0;
      miss    <= '0;
      present <= 1'b0;
    end else if (hs_edge) begin
      since <= CW'(1);
      gap   <= CW'(1);
      miss  <= '0;
      if (in_win) begin
        if (good != GOOD_MAX) good <= good + GW'(1);
        if (good >= GOOD_M1) present <= 1'b1;
      end else begin
        good <= '0;
      end
    end else begin
      if (since != SAT) since <= since + CW'(1);
      if (gap == WIN_HI) begin
        gap <= GAP_RST;
        if (miss != MISS_MAX) miss <= miss + MW'(1);
        if (miss >= MISS_M1) present <= 1'b0;
      end else begin
        gap <= gap + CW'(1);
      end
    end
  end

  // R2
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(hs_edge));
  // R4
  loss_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |-> !$past(hs_edge));
endmodule

// File: rtl/field_line_track.sv
module field_line_track
  import fld_l21_pkg::*;
#(
  parameter int H_PERIOD = 100,
  parameter int LINE_W   = 9,
  parameter int CW       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_edge,
  input  logic              vs_edge,
  input  logic [CW-1:0]     since,
  output logic [LINE_W-1:0] line_cnt,
  output field_e            field
);
  localparam logic [CW-1:0] MID_LO = CW'(H_PERIOD / 4);
  localparam logic [CW-1:0] MID_HI = CW'(3 * H_PERIOD / 4);
  localparam logic [LINE_W-1:0] LINE_SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= LINE_SAT;
      field    <= FLD_ODD;
    end else if (vs_edge) begin
      line_cnt <= '0;
      field    <= ((since >= MID_LO) && (since < MID_HI)) ? FLD_EVEN : FLD_ODD;
    end else if (hs_edge && (line_cnt != LINE_SAT)) begin
      line_cnt <= line_cnt + LINE_W'(1);
    end
  end

  // R7
  vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (line_cnt == '0));
  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(field));
endmodule

// File: rtl/fld_l21_top.sv
module fld_l21_top
  import fld_l21_pkg::*;
#(
  parameter int H_PERIOD    = 100,
  parameter int TOL_PCT     = 5,
  parameter int LOSS_CNT    = 4,
  parameter int LOCK_CNT    = 8,
  parameter int TARGET_LINE = 21,
  parameter int LINE_W      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync,
  input  logic vsync_n,
  input  logic l21_both,
  input  logic status_sel,
  output logic l21_pulse,
  output logic status_out
);
  localparam int CW = $clog2(2 * H_PERIOD + 1) + 1;
  localparam logic [LINE_W-1:0] TGT = LINE_W'(TARGET_LINE);

  logic cs_q1, cs_q2, vs_q1, vs_q2;
  logic hs_edge, vs_edge, present;
  logic [CW-1:0] since;
  logic [LINE_W-1:0] line_cnt;
  field_e field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q1 <= 1'b0;
      cs_q2 <= 1'b0;
      vs_q1 <= 1'b1;
      vs_q2 <= 1'b1;
    end else begin
      cs_q1 <= csync;
      cs_q2 <= cs_q1;
      vs_q1 <= vsync_n;
      vs_q2 <= vs_q1;
    end
  end

  assign hs_edge = cs_q1 & ~cs_q2;
  assign vs_edge = ~vs_q1 & vs_q2;

  hsync_judge #(
    .H_PERIOD(H_PERIOD), .TOL_PCT(TOL_PCT), .LOSS_CNT(LOSS_CNT),
    .LOCK_CNT(LOCK_CNT), .CW(CW)
  ) u_judge (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge),
    .present(present), .since(since)
  );

  field_line_track #(
    .H_PERIOD(H_PERIOD), .LINE_W(LINE_W), .CW(CW)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .since(since), .line_cnt(line_cnt), .field(field)
  );

  assign l21_pulse  = (line_cnt == TGT) && (l21_both || (field == FLD_EVEN));
  assign status_out = status_sel ? (field == FLD_EVEN) : present;

  // R8
  odd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l21_pulse && !l21_both) |-> (field == FLD_EVEN));
endmodule

// File: tb/fld_l21_top_bench.sv
module fld_l21_top_bench;
  localparam int HP = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b0;
  logic vsync_n = 1'b1;
  logic l21_both = 1'b0;
  logic status_sel = 1'b0;
  logic l21_pulse, status_out;

  int total = 0;
  int bad = 0;
  int hi_cnt = 0;
  int hi_total = 0;
  bit started = 1'b0;
  bit vs_prev = 1'b1;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  fld_l21_top u_fld_l21_top (
    .clk(clk), .rst_n(rst_n), .csync(csync), .vsync_n(vsync_n),
    .l21_both(l21_both), .status_sel(status_sel),
    .l21_pulse(l21_pulse), .status_out(status_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one line of `period` clocks; vertical edge at clock vs_off when vs_off >= 0
  task automatic hs_line(input int period, input int vs_off);
    for (int c = 0; c < period; c++) begin
      @(posedge clk);
      csync <= (c < 8);
      if (c == vs_off) vsync_n <= 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      csync <= 1'b0;
    end
  endtask

  // driver: one 30-line field, pushes the expected pulse width
  task automatic gen_field(input bit even, input bit both, input bit expect_pulse);
    l21_both <= both;
    status_sel <= 1'b1;
    exp_q.push_back(expect_pulse ? HP : 0);
    for (int ln = 0; ln < 30; ln++) begin
      if (ln == 3) vsync_n <= 1'b1;
      hs_line(HP, (ln == 0) ? (even ? 50 : 5) : -1);
      if (ln == 10) begin
        @(negedge clk);
        chk(status_out == even, "R6 field flag", status_out, even);
      end
    end
  endtask

  // monitor: measures pulse width per field, compares at each vertical edge
  always @(negedge clk) begin
    if (vs_prev && !vsync_n) begin
      if (started) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 scoreboard empty", hi_cnt, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(hi_cnt == e, (e != 0) ? "R7/R9 pulse width" : "R8 odd field no pulse", hi_cnt, e);
        end
      end
      started = 1'b1;
      hi_cnt = 0;
    end
    if (l21_pulse) begin
      hi_cnt++;
      hi_total++;
    end
    vs_prev = vsync_n;
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    chk(l21_pulse == 1'b0, "R1 pulse low", l21_pulse, 0);
    chk(status_out == 1'b0, "R1 absent", status_out, 0);
    status_sel <= 1'b1;
    @(negedge clk);
    chk(status_out == 1'b0, "R1 field odd", status_out, 0);
    status_sel <= 1'b0;

    for (int i = 0; i < 8; i++) hs_line(HP, -1);
    @(negedge clk);
    chk(status_out == 1'b0, "R2 seven intervals", status_out, 0);
    hs_line(HP, -1);
    @(negedge clk);
    chk(status_out == 1'b1, "R2 eighth interval", status_out, 1);
    for (int i = 0; i < 21; i++) hs_line(HP, -1);
    @(negedge clk);
    chk(hi_total == 0, "R10 no pulse without vsync", hi_total, 0);
    chk(status_out == 1'b1, "R5 present shown", status_out, 1);

    idle(250);
    @(negedge clk);
    chk(status_out == 1'b1, "R4 still present", status_out, 1);
    idle(100);
    @(negedge clk);
    chk(status_out == 1'b0, "R4 lost", status_out, 0);

    for (int i = 0; i < 12; i++) hs_line(110, -1);
    @(negedge clk);
    chk(status_out == 1'b0, "R3 long spacing", status_out, 0);
    for (int i = 0; i < 12; i++) hs_line(94, -1);
    @(negedge clk);
    chk(status_out == 1'b0, "R3 short spacing", status_out, 0);
    for (int i = 0; i < 10; i++) hs_line(104, -1);
    @(negedge clk);
    chk(status_out == 1'b1, "R2 edge of window", status_out, 1);

    gen_field(1'b0, 1'b0, 1'b0);
    gen_field(1'b1, 1'b0, 1'b1);
    gen_field(1'b0, 1'b1, 1'b1);
    gen_field(1'b1, 1'b1, 1'b1);
    gen_field(1'b0, 1'b0, 1'b0);
    hs_line(HP, 5);
    vsync_n <= 1'b1;
    idle(20);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all fields seen", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule